// File: doc/BRIEF.md
# Keyed Write-Protect Command Detector

This block watches the stream of byte writes accepted by a paged nonvolatile memory and detects two fixed command sequences of address/data pairs. A three-step key sequence arms software write protection and also authorizes the bytes that follow it in the same load window. A six-step key sequence arms the release of protection. Bytes that match a sequence step are command bytes and are never handed on to the page buffer.

For every accepted byte the block says in the same cycle whether that byte may pass to the page buffer. While protection is on, bytes not preceded by the key sequence are dropped. When a load window ends with nothing passed but with dropped bytes or a completed sequence, the block pulses a request so that the write controller runs a programming cycle that writes nothing. The protect flag changes only when the write controller reports the end of a programming cycle. A load window stays open as long as consecutive accepted bytes are no more than `GAP_CYCLES` clock cycles apart.

Top module: `wp_cmd_guard`

## Requirements
- R1: After reset `protect_o` is 0 and `dummy_start_o` is 0, and `pass_o` is 0 in any cycle without a write strobe.
- R2: While unprotected, a strobed byte that does not match the expected sequence step raises `pass_o` in the same cycle as `wr_valid_i`.
- R3: Key comparison uses only address bits 14:0 against 15'h5555 and 15'h2AAA and the full data byte; higher address bits are ignored. A byte matching the expected step gives `pass_o` = 0.
- R4: The arm sequence is data 8'hAA at 5555, 8'h55 at 2AAA, 8'hA0 at 5555; its completion sets `protect_o` to 1 in the cycle after the next `commit_i`, and not earlier.
- R5: While protected and not authorized, strobed bytes give `pass_o` = 0.
- R6: After a complete arm sequence, later bytes in the same load window pass even while protected; `protect_o` stays 1; the authorization ends when the window closes.
- R7: The release sequence is 8'hAA at 5555, 8'h55 at 2AAA, 8'h80 at 5555, 8'hAA at 5555, 8'h55 at 2AAA, 8'h20 at 5555; it authorizes later bytes in its window and clears `protect_o` in the cycle after the next `commit_i`.
- R8: A byte that fails the expected step returns the matcher to its first step and is itself treated as data under the current protection state; bytes that already matched earlier steps are not passed.
- R9: A window closes when `GAP_CYCLES` cycles pass with no strobe after the last one; a strobe exactly `GAP_CYCLES` cycles after the previous one continues the window, a later one starts a new window with the matcher at its first step.
- R10: At window close, if no byte passed and either a byte was dropped or a sequence completed, `dummy_start_o` is 1 for exactly one cycle, in the cycle after the closing edge; otherwise it stays 0.
- R11: `commit_i` with nothing armed leaves `protect_o` unchanged; when `commit_i` falls in the cycle of a sequence completion, it applies only what was armed before, and the new completion waits for the next `commit_i`.
- R12: Key addresses accept ordinary data: a non-key byte to 5555 or 2AAA passes when unprotected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | One accepted byte write this cycle |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | 8 | Byte value of the write |
| commit_i | input | 1 | End of a programming cycle, from the write controller |
| pass_o | output | 1 | Byte of this cycle may enter the page buffer |
| protect_o | output | 1 | Software write protection active |
| dummy_start_o | output | 1 | One-cycle request for a programming cycle that writes nothing |

## Verification
Two events can meet in one clock: a programming-cycle commit and the final byte of a key sequence, and likewise a window close and an arriving strobe at the gap limit. The bench lines up `commit_i` with the last key byte and with a strobe placed exactly at the limit, and judges that the earlier armed change alone lands while the new one waits for the following commit. A cycle-level reference model in the bench tracks every strobe, idle cycle and commit of the random phase and compares `pass_o`, `protect_o` and `dummy_start_o` each cycle.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int unsigned KEY_W = 15;
  localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] KEY_D_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_D_SECOND = 8'h55;
  localparam logic [7:0] KEY_D_ARM    = 8'hA0;
  localparam logic [7:0] KEY_D_BRANCH = 8'h80;
  localparam logic [7:0] KEY_D_REL    = 8'h20;

  typedef enum logic [2:0] {
    ST_K0, ST_K1, ST_K2, ST_R3, ST_R4, ST_R5
  } step_e;

  function automatic logic step_match(step_e s, logic [KEY_W-1:0] a, logic [7:0] d);
    unique case (s)
      ST_K0, ST_R3: step_match = (a == KEY_ADDR_A) && (d == KEY_D_FIRST);
      ST_K1, ST_R4: step_match = (a == KEY_ADDR_B) && (d == KEY_D_SECOND);
      ST_K2:        step_match = (a == KEY_ADDR_A) && (d == KEY_D_ARM || d == KEY_D_BRANCH);
      ST_R5:        step_match = (a == KEY_ADDR_A) && (d == KEY_D_REL);
      default:      step_match = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/wpg_matcher.sv
module wpg_matcher
  import wpg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] key_addr_i,
  input  logic [7:0]       data_i,
  input  logic             flush_i,
  output logic             hit_o,
  output logic             arm_done_o,
  output logic             rel_done_o
);
  step_e step_q, step_d;
  logic  match;

  assign match      = step_match(step_q, key_addr_i, data_i);
  assign hit_o      = wr_i && match;
  assign arm_done_o = hit_o && (step_q == ST_K2) && (data_i == KEY_D_ARM);
  assign rel_done_o = hit_o && (step_q == ST_R5);

  always_comb begin
    step_d = step_q;
    if (wr_i) begin
      if (!match || arm_done_o || rel_done_o) begin
        step_d = ST_K0;
      end else begin
        unique case (step_q)
          ST_K0:   step_d = ST_K1;
          ST_K1:   step_d = ST_K2;
          ST_K2:   step_d = ST_R3;
          ST_R3:   step_d = ST_R4;
          ST_R4:   step_d = ST_R5;
          default: step_d = ST_K0;
        endcase
      end
    end else if (flush_i) begin
      step_d = ST_K0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_K0;
    else         step_q <= step_d;
  end
endmodule

// File: rtl/wpg_window.sv
module wpg_window #(
  parameter int unsigned GAP_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  output logic close_o
);
  localparam int unsigned CNT_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP_CYCLES - 1);

  logic             open_q;
  logic [CNT_W-1:0] cnt_q;

  assign close_o = open_q && !wr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (wr_i) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
    end else if (close_o) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (open_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wpg_state.sv
module wpg_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic hit_i,
  input  logic arm_done_i,
  input  logic rel_done_i,
  input  logic close_i,
  input  logic commit_i,
  output logic pass_o,
  output logic protect_o,
  output logic dummy_o
);
  logic prot_q, arm_q, rel_q, auth_q;
  logic drop_seen_q, pass_seen_q, cmd_seen_q, dummy_q;
  logic drop;

  assign pass_o    = wr_i && !hit_i && (!prot_q || auth_q);
  assign drop      = wr_i && !hit_i && prot_q && !auth_q;
  assign protect_o = prot_q;
  assign dummy_o   = dummy_q;

  // protection only moves on a commit, from what was armed before it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= 1'b0;
      arm_q  <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      if (commit_i) begin
        if (arm_q)      prot_q <= 1'b1;
        else if (rel_q) prot_q <= 1'b0;
      end
      if (arm_done_i || rel_done_i) begin
        arm_q <= arm_done_i;
        rel_q <= rel_done_i;
      end else if (commit_i) begin
        arm_q <= 1'b0;
        rel_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auth_q      <= 1'b0;
      drop_seen_q <= 1'b0;
      pass_seen_q <= 1'b0;
      cmd_seen_q  <= 1'b0;
      dummy_q     <= 1'b0;
    end else begin
      dummy_q <= 1'b0;
      if (close_i) begin
        dummy_q     <= (drop_seen_q || cmd_seen_q) && !pass_seen_q;
        auth_q      <= 1'b0;
        drop_seen_q <= 1'b0;
        pass_seen_q <= 1'b0;
        cmd_seen_q  <= 1'b0;
      end else begin
        if (arm_done_i || rel_done_i) begin
          auth_q     <= 1'b1;
          cmd_seen_q <= 1'b1;
        end
        if (drop)   drop_seen_q <= 1'b1;
        if (pass_o) pass_seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard
  import wpg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned GAP_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              commit_i,
  output logic              pass_o,
  output logic              protect_o,
  output logic              dummy_start_o
);
  logic hit, arm_done, rel_done, close;

  wpg_matcher u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_valid_i),
    .key_addr_i (wr_addr_i[KEY_W-1:0]),
    .data_i     (wr_data_i),
    .flush_i    (close),
    .hit_o      (hit),
    .arm_done_o (arm_done),
    .rel_done_o (rel_done)
  );

  wpg_window #(.GAP_CYCLES(GAP_CYCLES)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_valid_i),
    .close_o (close)
  );

  wpg_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_valid_i),
    .hit_i      (hit),
    .arm_done_i (arm_done),
    .rel_done_i (rel_done),
    .close_i    (close),
    .commit_i   (commit_i),
    .pass_o     (pass_o),
    .protect_o  (protect_o),
    .dummy_o    (dummy_start_o)
  );
endmodule

// File: rtl/wp_cmd_guard_chk.sv
module wp_cmd_guard_chk #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              commit_i,
  input logic              pass_o,
  input logic              protect_o,
  input logic              dummy_start_o
);
  assert_protect_moves_on_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protect_o != $past(protect_o)) |-> $past(commit_i));

  assert_pass_needs_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> wr_valid_i);

  // a byte to a non-key address can never be a command byte
  assert_plain_byte_passes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !protect_o && wr_addr_i[14:0] != 15'h5555 && wr_addr_i[14:0] != 15'h2AAA)
      |-> pass_o);

  assert_dummy_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_start_o |=> !dummy_start_o);

  assert_dummy_after_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_start_o |-> !$past(wr_valid_i));
endmodule

bind wp_cmd_guard wp_cmd_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_valid_i    (wr_valid_i),
  .wr_addr_i     (wr_addr_i),
  .commit_i      (commit_i),
  .pass_o        (pass_o),
  .protect_o     (protect_o),
  .dummy_start_o (dummy_start_o)
);

// File: tb/wp_cmd_guard_test.sv
module wp_cmd_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 17;
  localparam int GAP = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_valid_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [7:0]        wr_data_i = '0;
  logic              commit_i = 1'b0;
  logic              pass_o, protect_o, dummy_start_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // reference model
  bit m_prot, m_arm, m_rel, m_auth, m_open, m_drop, m_pass, m_cmd, m_dummy;
  int m_step, m_cnt;

  wp_cmd_guard #(.ADDR_W(ADDR_W), .GAP_CYCLES(GAP)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .commit_i(commit_i), .pass_o(pass_o),
    .protect_o(protect_o), .dummy_start_o(dummy_start_o));

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic bit key_hit(int st, logic [14:0] a, logic [7:0] d);
    case (st)
      0, 3: return a == 15'h5555 && d == 8'hAA;
      1, 4: return a == 15'h2AAA && d == 8'h55;
      2:    return a == 15'h5555 && (d == 8'hA0 || d == 8'h80);
      5:    return a == 15'h5555 && d == 8'h20;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string t, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  // one clock cycle: drive, check same-cycle pass, advance model, check registered outputs
  task automatic cyc(bit w, logic [ADDR_W-1:0] a, logic [7:0] d, bit c);
    bit h, ep, en, dis;
    @(negedge clk_i);
    wr_valid_i = w; wr_addr_i = a; wr_data_i = d; commit_i = c;
    #1;
    h  = w && key_hit(m_step, a[14:0], d);
    ep = w && !h && (!m_prot || m_auth);
    en = h && m_step == 2 && d == 8'hA0;
    dis = h && m_step == 5;
    check(tag, "pass_o", pass_o, ep);
    m_dummy = 0;
    if (c) begin
      if (m_arm) m_prot = 1; else if (m_rel) m_prot = 0;
      m_arm = 0; m_rel = 0;
    end
    if (en || dis) begin m_arm = en; m_rel = dis; end
    if (w) begin
      m_open = 1; m_cnt = 0;
      if (h) begin
        if (en || dis) begin m_step = 0; m_auth = 1; m_cmd = 1; end
        else m_step++;
      end else begin
        m_step = 0;
        if (ep) m_pass = 1; else m_drop = 1;
      end
    end else if (m_open) begin
      if (m_cnt == GAP-1) begin
        m_open = 0; m_step = 0;
        m_dummy = (m_drop || m_cmd) && !m_pass;
        m_auth = 0; m_drop = 0; m_pass = 0; m_cmd = 0;
      end else m_cnt++;
    end
    @(posedge clk_i); #1;
    check(tag, "protect_o", protect_o, m_prot);
    check(tag, "dummy_start_o", dummy_start_o, m_dummy);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d); cyc(1, a, d, 0); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, '0, '0, 0); endtask
  task automatic commit(); cyc(0, '0, '0, 1); endtask
  task automatic arm_seq(); wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0); endtask
  task automatic rel_seq();
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h20);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state
    check("R1", "protect_o", protect_o, 0);
    check("R1", "dummy_start_o", dummy_start_o, 0);
    check("R1", "pass_o", pass_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    idle(2);

    tag = "R2"; wr(17'h00123, 8'h3C); wr(17'h1ABCD, 8'hFF); idle(GAP + 2);
    tag = "R12"; wr(17'h05555, 8'h12); wr(17'h02AAA, 8'hAA); idle(GAP + 2);
    // R3: upper address bits ignored for keys
    tag = "R3"; wr(17'h15555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h1D555, 8'hA0);
    idle(GAP + 2);  // R10: command-only window requests a dummy cycle
    tag = "R4"; check("R4", "protect before commit", protect_o, 0);
    commit(); check("R4", "protect after commit", protect_o, 1);
    tag = "R11"; commit(); check("R11", "protect idle commit", protect_o, 1);
    tag = "R5"; wr(17'h00400, 8'h11); wr(17'h00401, 8'h22); idle(GAP + 2);
    tag = "R6"; arm_seq(); wr(17'h00500, 8'h33); wr(17'h05555, 8'h44); idle(GAP + 1);
    check("R6", "protect stays", protect_o, 1);
    wr(17'h00501, 8'h55); idle(GAP + 2);
    commit();
    // R9: strobe exactly at the gap limit continues, one more cycle breaks
    tag = "R9"; wr(17'h05555, 8'hAA); idle(GAP - 1); wr(17'h02AAA, 8'h55);
    idle(GAP); wr(17'h05555, 8'hA0); idle(GAP + 2);
    // R8: mismatch restarts the matcher and the byte is data
    tag = "R8"; wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h56); idle(GAP + 2);
    // R7 + R11: release, last key byte meets a commit
    tag = "R7"; arm_seq(); idle(GAP + 2);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55);
    tag = "R11"; cyc(1, 17'h05555, 8'h20, 1);
    check("R11", "old arm applied", protect_o, 1);
    tag = "R7"; wr(17'h00600, 8'h66); idle(GAP + 2);
    commit(); check("R7", "protect cleared", protect_o, 0);
    tag = "R2"; wr(17'h00700, 8'h77); idle(GAP + 2);

    tag = "RND";
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [ADDR_W-1:0] a;
      logic [7:0] d;
      op = $urandom_range(0, 99);
      if (op < 4) arm_seq();
      else if (op < 6) rel_seq();
      else if (op < 10) commit();
      else if (op < 45) begin
        case ($urandom_range(0, 2))
          0: a = 17'h05555;
          1: a = 17'h02AAA;
          default: a = ADDR_W'($urandom);
        endcase
        case ($urandom_range(0, 5))
          0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'hA0; 3: d = 8'h80; 4: d = 8'h20;
          default: d = 8'($urandom);
        endcase
        cyc(1, a, d, $urandom_range(0, 15) == 0);
      end else idle($urandom_range(1, GAP + 3));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule